// File: doc/BRIEF.md
# PC Keyboard Controller Command Decoder

This block is the host-side command engine of a PS/2 keyboard and mouse controller. The host performs byte writes to one of two ports: a data port and a command port. Each write arrives as a single-cycle strobe carrying an address bit and a byte. The block holds four pieces of state:

- the mode byte,
- the output-port byte,
- the self-test and last-write-kind status flags,
- a latched pending command.

From these it builds the status byte that a command-port read returns.

Most commands act at once. Some queue a one-byte reply to the output-buffer arbiter. Some change mode bits, and some drive the A20 gate or a reset request. A separate family of commands only arms the pending-command latch. The next data-port write is then consumed according to that latch, and the latch returns to idle. A data write that arrives with nothing pending goes to the keyboard transmitter.

The pending latch is a state machine with six states:

| State | Meaning |
|---|---|
| `PEND_NONE` | idle |
| `PEND_MODE` | next data byte is the new mode byte |
| `PEND_OPORT` | next data byte is the new output-port byte |
| `PEND_OBUF_KBD` | next data byte is a reply marked as keyboard |
| `PEND_OBUF_AUX` | next data byte is a reply marked as mouse |
| `PEND_AUX_TX` | next data byte goes to the mouse transmitter |

It has three transitions:

- **arm**: a latching command moves from any state to its target state.
- **consume**: any data write moves to `PEND_NONE`.
- **hold**: any other command, or no write, keeps the state.

All registered outputs change on the clock edge that samples the strobe.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset, the block presents the following values, and no pulse output is active:

  | Output | Reset value |
  |---|---|
  | mode byte | 0x03 |
  | output-port byte | 0xCF |
  | status byte | 0x18 (with both buffer-full inputs low) |
  | A20 gate | 1 |
  | translation enable | 0 |

- R2: The status byte is assembled as follows:

  | Bit | Content |
  |---|---|
  | 0 | the `obuf_full` input |
  | 1 | always 0 |
  | 2 | the self-test flag |
  | 3 | 1 after a command write, 0 after a data write |
  | 4 | always 1 |
  | 5 | the `obuf_aux` input |
  | 6, 7 | always 0 |

- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no output. Each arms the pending latch. The following data write is consumed by that latch, and the latch then returns to idle.
- R4: Reply commands put a byte on `resp_byte` with `resp_valid` high for one cycle and `resp_aux` low:

  | Command | Reply |
  |---|---|
  | 0x20 | the mode byte |
  | 0xA9 | 0x00 |
  | 0xAB | 0x00 |
  | 0xC0 | 0x80 |
  | 0xD0 | the output-port byte |
  | 0xAA | 0x55, and status bit 2 is set |

- R5: Mode bit 5 is the mouse-disable bit: 0xA7 sets it and 0xA8 clears it. Mode bit 4 is the keyboard-disable bit: 0xAD sets it and 0xAE clears it.
- R6: A command whose upper nibble is 0xF is a pulse command. If its bit 0 is 0, `sys_reset_req` is high for exactly one cycle. If bit 0 is 1, the command has no effect.
- R7: A data byte following 0xD1 becomes the output-port byte. The A20 gate follows bit 1 of that byte. If bit 0 of the byte is 0, a one-cycle reset request is issued.
- R8: Command 0xDF sets output-port bit 1 and the A20 gate. Command 0xDD clears both.
- R9: A data write with nothing pending is sent on the keyboard transmit outputs and clears mode bit 4. A data byte following 0xD4 is sent on the mouse transmit outputs and clears mode bit 5.
- R10: A data byte following 0x60 replaces the mode byte. `xlate_en` equals mode bit 6 from the same edge.
- R11: A data byte following 0xD2 is issued as a reply with `resp_aux` = 0. A data byte following 0xD3 is issued as a reply with `resp_aux` = 1.
- R12: Unrecognised commands change neither the mode byte, the output port, the self-test flag nor any output; they only set status bit 3. A non-latching command leaves an armed latch armed.
- R13: The two interrupt outputs are driven from the buffer-full inputs and the mode byte:
  - `irq_kbd` = obuf_full AND NOT obuf_aux AND mode bit 0 AND NOT mode bit 4.
  - `irq_aux` = obuf_full AND obuf_aux AND mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle host write strobe |
| wr_is_cmd | input | 1 | 1 = command port, 0 = data port |
| wr_byte | input | 8 | Written byte |
| obuf_full | input | 1 | Output buffer holds a byte (from arbiter) |
| obuf_aux | input | 1 | Held byte came from the mouse side |
| status_byte | output | 8 | Status byte returned on a command-port read |
| mode_byte | output | 8 | Current mode byte |
| oport_byte | output | 8 | Current output-port byte |
| a20_gate | output | 1 | A20 gate level (output-port bit 1) |
| sys_reset_req | output | 1 | One-cycle system reset request |
| resp_valid | output | 1 | Reply byte strobe to the output-buffer arbiter |
| resp_byte | output | 8 | Reply byte |
| resp_aux | output | 1 | Reply is marked as mouse data |
| kbd_tx_valid | output | 1 | Byte strobe to the keyboard transmitter |
| kbd_tx_byte | output | 8 | Byte for the keyboard |
| aux_tx_valid | output | 1 | Byte strobe to the mouse transmitter |
| aux_tx_byte | output | 8 | Byte for the mouse |
| xlate_en | output | 1 | Scan-code translation enable (mode bit 6) |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Mouse interrupt level |

## Verification
A wrong pending state shows at the ports on the very next data write. The byte then appears on the wrong transmitter, replaces the wrong register, or leaves as a reply with the wrong source flag. A corrupted mode or output-port byte is visible one edge after the write that caused it: on `mode_byte`, `oport_byte`, `a20_gate` or `xlate_en`, and through the interrupt levels. A mis-decoded pulse command shows as a missing or extra one-cycle reset request in the cycle after the strobe.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;

    localparam int MODE_KIRQ_BIT  = 0;
    localparam int MODE_AIRQ_BIT  = 1;
    localparam int MODE_KDIS_BIT  = 4;
    localparam int MODE_ADIS_BIT  = 5;
    localparam int MODE_XLAT_BIT  = 6;
    localparam int OPORT_RUN_BIT  = 0;
    localparam int OPORT_A20_BIT  = 1;

    typedef enum logic [2:0] {
        PEND_NONE     = 3'd0,
        PEND_MODE     = 3'd1,
        PEND_OPORT    = 3'd2,
        PEND_OBUF_KBD = 3'd3,
        PEND_OBUF_AUX = 3'd4,
        PEND_AUX_TX   = 3'd5
    } pend_e;

    typedef enum logic [1:0] {
        RSP_CONST = 2'd0,
        RSP_MODE  = 2'd1,
        RSP_OPORT = 2'd2
    } rsp_sel_e;

    typedef struct packed {
        logic              arm;
        pend_e             arm_to;
        logic              resp;
        rsp_sel_e          resp_sel;
        logic [BYTE_W-1:0] resp_const;
        logic              selftest;
        logic [BYTE_W-1:0] mode_set;
        logic [BYTE_W-1:0] mode_clr;
        logic              a20_set;
        logic              a20_clr;
        logic              rst_pulse;
    } cmd_dec_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SELFTEST_REPLY = 8'h55,
    parameter logic [BYTE_W-1:0] INPORT_VALUE   = 8'h80,
    parameter logic [BYTE_W-1:0] TEST_REPLY     = 8'h00
) (
    input  logic [BYTE_W-1:0] cmd,
    output cmd_dec_t          dec
);
    localparam logic [3:0] PULSE_NIB = 4'hF;

    always_comb begin
        dec = '0;
        dec.arm_to   = PEND_NONE;
        dec.resp_sel = RSP_CONST;
        if (cmd[BYTE_W-1 -: 4] == PULSE_NIB) begin
            dec.rst_pulse = ~cmd[0];
        end else begin
            case (cmd)
                8'h20: begin dec.resp = 1'b1; dec.resp_sel = RSP_MODE; end
                8'h60: begin dec.arm = 1'b1; dec.arm_to = PEND_MODE; end
                8'hD1: begin dec.arm = 1'b1; dec.arm_to = PEND_OPORT; end
                8'hD2: begin dec.arm = 1'b1; dec.arm_to = PEND_OBUF_KBD; end
                8'hD3: begin dec.arm = 1'b1; dec.arm_to = PEND_OBUF_AUX; end
                8'hD4: begin dec.arm = 1'b1; dec.arm_to = PEND_AUX_TX; end
                8'hA7: dec.mode_set[MODE_ADIS_BIT] = 1'b1;
                8'hA8: dec.mode_clr[MODE_ADIS_BIT] = 1'b1;
                8'hAD: dec.mode_set[MODE_KDIS_BIT] = 1'b1;
                8'hAE: dec.mode_clr[MODE_KDIS_BIT] = 1'b1;
                8'hA9, 8'hAB: begin
                    dec.resp = 1'b1; dec.resp_const = TEST_REPLY;
                end
                8'hAA: begin
                    dec.resp = 1'b1; dec.resp_const = SELFTEST_REPLY;
                    dec.selftest = 1'b1;
                end
                8'hC0: begin dec.resp = 1'b1; dec.resp_const = INPORT_VALUE; end
                8'hD0: begin dec.resp = 1'b1; dec.resp_sel = RSP_OPORT; end
                8'hDF: dec.a20_set = 1'b1;
                8'hDD: dec.a20_clr = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/kbc_pend_fsm.sv
module kbc_pend_fsm
    import kbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_wr,
    input  logic  dat_wr,
    input  logic  arm,
    input  pend_e arm_to,
    output pend_e state
);
    pend_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PEND_NONE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (dat_wr)                 state_nx = PEND_NONE;
        else if (cmd_wr && arm)     state_nx = arm_to;
    end

    assert_latch_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> (state == PEND_NONE));

    assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !arm) |=> $stable(state));
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST       = 8'h03,
    parameter logic [BYTE_W-1:0] OPORT_RST      = 8'hCF,
    parameter logic [BYTE_W-1:0] SELFTEST_REPLY = 8'h55,
    parameter logic [BYTE_W-1:0] INPORT_VALUE   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_is_cmd,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              obuf_full,
    input  logic              obuf_aux,
    output logic [BYTE_W-1:0] status_byte,
    output logic [BYTE_W-1:0] mode_byte,
    output logic [BYTE_W-1:0] oport_byte,
    output logic              a20_gate,
    output logic              sys_reset_req,
    output logic              resp_valid,
    output logic [BYTE_W-1:0] resp_byte,
    output logic              resp_aux,
    output logic              kbd_tx_valid,
    output logic [BYTE_W-1:0] kbd_tx_byte,
    output logic              aux_tx_valid,
    output logic [BYTE_W-1:0] aux_tx_byte,
    output logic              xlate_en,
    output logic              irq_kbd,
    output logic              irq_aux
);
    logic     cmd_wr, dat_wr;
    cmd_dec_t dec;
    pend_e    pend;
    logic     selftest_q, lastcmd_q;

    assign cmd_wr = wr_stb &  wr_is_cmd;
    assign dat_wr = wr_stb & ~wr_is_cmd;

    kbc_cmd_decode #(
        .SELFTEST_REPLY (SELFTEST_REPLY),
        .INPORT_VALUE   (INPORT_VALUE),
        .TEST_REPLY     (8'h00)
    ) u_dec (
        .cmd (wr_byte),
        .dec (dec)
    );

    kbc_pend_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (cmd_wr),
        .dat_wr (dat_wr),
        .arm    (dec.arm),
        .arm_to (dec.arm_to),
        .state  (pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_byte     <= MODE_RST;
            oport_byte    <= OPORT_RST;
            selftest_q    <= 1'b0;
            lastcmd_q     <= 1'b1;
            sys_reset_req <= 1'b0;
            resp_valid    <= 1'b0;
            resp_byte     <= '0;
            resp_aux      <= 1'b0;
            kbd_tx_valid  <= 1'b0;
            kbd_tx_byte   <= '0;
            aux_tx_valid  <= 1'b0;
            aux_tx_byte   <= '0;
        end else begin
            sys_reset_req <= 1'b0;
            resp_valid    <= 1'b0;
            kbd_tx_valid  <= 1'b0;
            aux_tx_valid  <= 1'b0;
            if (cmd_wr) begin
                lastcmd_q <= 1'b1;
                if (dec.selftest) selftest_q <= 1'b1;
                mode_byte <= (mode_byte | dec.mode_set) & ~dec.mode_clr;
                if (dec.a20_set) oport_byte[OPORT_A20_BIT] <= 1'b1;
                if (dec.a20_clr) oport_byte[OPORT_A20_BIT] <= 1'b0;
                sys_reset_req <= dec.rst_pulse;
                if (dec.resp) begin
                    resp_valid <= 1'b1;
                    resp_aux   <= 1'b0;
                    unique case (dec.resp_sel)
                        RSP_MODE:  resp_byte <= mode_byte;
                        RSP_OPORT: resp_byte <= oport_byte;
                        default:   resp_byte <= dec.resp_const;
                    endcase
                end
            end else if (dat_wr) begin
                lastcmd_q <= 1'b0;
                unique case (pend)
                    PEND_MODE:  mode_byte <= wr_byte;
                    PEND_OPORT: begin
                        oport_byte    <= wr_byte;
                        sys_reset_req <= ~wr_byte[OPORT_RUN_BIT];
                    end
                    PEND_OBUF_KBD, PEND_OBUF_AUX: begin
                        resp_valid <= 1'b1;
                        resp_byte  <= wr_byte;
                        resp_aux   <= (pend == PEND_OBUF_AUX);
                    end
                    PEND_AUX_TX: begin
                        aux_tx_valid <= 1'b1;
                        aux_tx_byte  <= wr_byte;
                        mode_byte[MODE_ADIS_BIT] <= 1'b0;
                    end
                    default: begin
                        kbd_tx_valid <= 1'b1;
                        kbd_tx_byte  <= wr_byte;
                        mode_byte[MODE_KDIS_BIT] <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign status_byte = {2'b00, obuf_aux, 1'b1, lastcmd_q, selftest_q, 1'b0, obuf_full};
    assign a20_gate    = oport_byte[OPORT_A20_BIT];
    assign xlate_en    = mode_byte[MODE_XLAT_BIT];
    assign irq_kbd     = obuf_full & ~obuf_aux & mode_byte[MODE_KIRQ_BIT] & ~mode_byte[MODE_KDIS_BIT];
    assign irq_aux     = obuf_full &  obuf_aux & mode_byte[MODE_AIRQ_BIT];

    assert_reset_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(wr_stb));

    assert_resp_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(wr_stb));

    assert_tx_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_tx_valid && aux_tx_valid));

    assert_kbd_tx_from_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_tx_valid |-> $past(wr_stb && !wr_is_cmd));

    assert_a20_moves_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a20_gate) |-> $past(wr_stb));

    assert_lastcmd_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && wr_is_cmd) |-> status_byte[3]);
endmodule

// File: tb/tb_kbc_cmd_engine.sv
module tb_kbc_cmd_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, wr_is_cmd = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       obuf_full = 1'b0, obuf_aux = 1'b0;
    logic [7:0] status_byte, mode_byte, oport_byte, resp_byte, kbd_tx_byte, aux_tx_byte;
    logic       a20_gate, sys_reset_req, resp_valid, resp_aux;
    logic       kbd_tx_valid, aux_tx_valid, xlate_en, irq_kbd, irq_aux;

    int n_tests = 0, n_fail = 0;

    // reference state
    logic [7:0] m_mode, m_oport;
    logic       m_self, m_last;
    int         m_pend;

    always #5 clk = ~clk;

    kbc_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
        .obuf_full(obuf_full), .obuf_aux(obuf_aux), .status_byte(status_byte),
        .mode_byte(mode_byte), .oport_byte(oport_byte), .a20_gate(a20_gate),
        .sys_reset_req(sys_reset_req), .resp_valid(resp_valid), .resp_byte(resp_byte),
        .resp_aux(resp_aux), .kbd_tx_valid(kbd_tx_valid), .kbd_tx_byte(kbd_tx_byte),
        .aux_tx_valid(aux_tx_valid), .aux_tx_byte(aux_tx_byte), .xlate_en(xlate_en),
        .irq_kbd(irq_kbd), .irq_aux(irq_aux)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {2'b00, obuf_aux, 1'b1, m_last, m_self, 1'b0, obuf_full};
    endfunction

    function automatic logic exp_irq_kbd();
        return obuf_full & ~obuf_aux & m_mode[0] & ~m_mode[4];
    endfunction

    function automatic logic exp_irq_aux();
        return obuf_full & obuf_aux & m_mode[1];
    endfunction

    task automatic check_static(input string tag);
        chk("R2", "status", status_byte, exp_status());
        chk(tag, "mode", mode_byte, m_mode);
        chk(tag, "oport", oport_byte, m_oport);
        chk("R7", "a20", a20_gate, m_oport[1]);
        chk("R10", "xlate", xlate_en, m_mode[6]);
        chk("R13", "irq_kbd", irq_kbd, exp_irq_kbd());
        chk("R13", "irq_aux", irq_aux, exp_irq_aux());
    endtask

    task automatic do_write(input logic is_cmd, input logic [7:0] b);
        logic       e_rv = 0, e_ra = 0, e_kv = 0, e_av = 0, e_rst = 0;
        logic [7:0] e_rb = 0;
        string      tag = "R12";
        if (is_cmd) begin
            m_last = 1'b1;
            if (b[7:4] == 4'hF) begin
                e_rst = ~b[0]; tag = "R6";
            end else begin
                case (b)
                    8'h20: begin e_rv = 1; e_rb = m_mode; tag = "R4"; end
                    8'h60: begin m_pend = 1; tag = "R3"; end
                    8'hD1: begin m_pend = 2; tag = "R3"; end
                    8'hD2: begin m_pend = 3; tag = "R3"; end
                    8'hD3: begin m_pend = 4; tag = "R3"; end
                    8'hD4: begin m_pend = 5; tag = "R3"; end
                    8'hA7: begin m_mode[5] = 1; tag = "R5"; end
                    8'hA8: begin m_mode[5] = 0; tag = "R5"; end
                    8'hAD: begin m_mode[4] = 1; tag = "R5"; end
                    8'hAE: begin m_mode[4] = 0; tag = "R5"; end
                    8'hA9, 8'hAB: begin e_rv = 1; e_rb = 8'h00; tag = "R4"; end
                    8'hAA: begin e_rv = 1; e_rb = 8'h55; m_self = 1; tag = "R4"; end
                    8'hC0: begin e_rv = 1; e_rb = 8'h80; tag = "R4"; end
                    8'hD0: begin e_rv = 1; e_rb = m_oport; tag = "R4"; end
                    8'hDF: begin m_oport[1] = 1; tag = "R8"; end
                    8'hDD: begin m_oport[1] = 0; tag = "R8"; end
                    default: tag = "R12";
                endcase
            end
        end else begin
            m_last = 1'b0;
            case (m_pend)
                1: begin m_mode = b; tag = "R10"; end
                2: begin m_oport = b; e_rst = ~b[0]; tag = "R7"; end
                3: begin e_rv = 1; e_rb = b; e_ra = 0; tag = "R11"; end
                4: begin e_rv = 1; e_rb = b; e_ra = 1; tag = "R11"; end
                5: begin e_av = 1; m_mode[5] = 0; tag = "R9"; end
                default: begin e_kv = 1; m_mode[4] = 0; tag = "R9"; end
            endcase
            m_pend = 0;
        end
        @(negedge clk);
        wr_stb = 1'b1; wr_is_cmd = is_cmd; wr_byte = b;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(tag, "resp_valid", resp_valid, e_rv);
        if (e_rv) begin
            chk(tag, "resp_byte", resp_byte, e_rb);
            chk(tag, "resp_aux", resp_aux, e_ra);
        end
        chk(tag, "kbd_tx_valid", kbd_tx_valid, e_kv);
        if (e_kv) chk(tag, "kbd_tx_byte", kbd_tx_byte, b);
        chk(tag, "aux_tx_valid", aux_tx_valid, e_av);
        if (e_av) chk(tag, "aux_tx_byte", aux_tx_byte, b);
        chk(tag, "sys_reset_req", sys_reset_req, e_rst);
        check_static(tag);
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] cmds [24] = '{8'h20, 8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hA7, 8'hA8,
                                  8'hAD, 8'hAE, 8'hA9, 8'hAB, 8'hAA, 8'hC0, 8'hD0, 8'hDF,
                                  8'hDD, 8'hFE, 8'hFF, 8'hF0, 8'hF3, 8'h42, 8'hB5, 8'h00};
        m_mode = 8'h03; m_oport = 8'hCF; m_self = 0; m_last = 1; m_pend = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1", "mode", mode_byte, 8'h03);
        chk("R1", "oport", oport_byte, 8'hCF);
        chk("R1", "status", status_byte, 8'h18);
        chk("R1", "a20", a20_gate, 1'b1);
        chk("R1", "xlate", xlate_en, 1'b0);
        chk("R1", "pulses", {sys_reset_req, resp_valid, kbd_tx_valid, aux_tx_valid}, 4'h0);

        // R6 pulse family
        do_write(1, 8'hFE);
        @(negedge clk);
        chk("R6", "reset pulse one cycle", sys_reset_req, 1'b0);
        do_write(1, 8'hFF);
        do_write(1, 8'hF1);
        do_write(1, 8'hF0);
        // R7 output-port write with reset bit low and A20 low
        do_write(1, 8'hD1); do_write(0, 8'hCC);
        do_write(1, 8'hD0);
        do_write(1, 8'hD1); do_write(0, 8'hCF);
        // R8
        do_write(1, 8'hDD); do_write(1, 8'hDF);
        // R12 unknown command, and a latch survives a non-latching command
        do_write(1, 8'h5A);
        do_write(1, 8'hD4); do_write(1, 8'h3C); do_write(1, 8'hA9); do_write(0, 8'hF4);
        // R10 mode write with translation bit
        do_write(1, 8'h60); do_write(0, 8'h43);
        do_write(1, 8'h20);
        // R11 both reply sources
        do_write(1, 8'hD2); do_write(0, 8'h9A);
        do_write(1, 8'hD3); do_write(0, 8'h5B);
        // R9 keyboard path clears disable
        do_write(1, 8'hAD); do_write(0, 8'hED);
        // R5 / R4 self-test
        do_write(1, 8'hA7); do_write(1, 8'hA8); do_write(1, 8'hAA); do_write(1, 8'hC0);
        // R13 interrupt levels
        obuf_full = 1; obuf_aux = 0; do_write(1, 8'hAE);
        obuf_aux = 1; do_write(1, 8'hAD);
        obuf_aux = 0; do_write(1, 8'hAB);

        for (int i = 0; i < 400; i++) begin
            obuf_full = $urandom_range(1, 0) != 0;
            obuf_aux  = $urandom_range(1, 0) != 0;
            if ($urandom_range(2, 0) == 0) do_write(0, 8'($urandom_range(255, 0)));
            else                           do_write(1, cmds[$urandom_range(23, 0)]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule